// File: doc/BRIEF.md
# Simultaneous-Multithreading Issue Slot Allocator

This block decides, once per cycle, which hardware threads of a simultaneous multithreaded core get which of the core's shared issue slots. Each of eight thread contexts presents a count of ready instructions, and every instruction carries a unit-class tag. The eight slots are typed: four feed integer units, two feed floating-point units and two feed load/store units. Threads are served strictly by context number. Thread 0 picks first. Each later thread can only use the slots that the threads before it left free, so several threads can issue in the same cycle.

Three mode inputs shape the allocation. A cap code limits how many instructions any one thread may issue in a cycle. A paired-integer mode ties each integer slot to two fixed threads. A single-thread mode lets only one thread issue per cycle, and that thread is picked by a rotating pointer. Requests and modes are captured in a register stage. The allocation is computed from those registers, and the grants are registered on the next edge. The result is a per-slot valid bit with the index of the owning thread, and a per-thread count of issued instructions.

Top module: `smt_issue_alloc`

## Requirements
- R1: A synchronous active-high reset clears every slot valid bit, every slot owner field and every per-thread count within one clock edge. It also returns the rotating pointer to thread 0.
- R2: Requests and modes are sampled on one clock edge, and the grants they produce appear on the outputs after the following edge (two-edge latency).
- R3: Threads are served in ascending context order. A thread can only take slots left free by all lower-numbered threads. Each granted instruction takes the lowest-numbered free slot of its class.
- R4: Slots 0 to 3 are integer, slots 4 to 5 are floating point and slots 6 to 7 are load/store. Class code 0 is integer, 1 is floating point and 2 is load/store. An instruction is granted only a slot of its own class.
- R5: A thread's instructions are considered in order, from index 0 upward. The first instruction that finds no slot stops that thread for the cycle. The thread's count is the number of instructions placed before that point.
- R6: Cap code 0 allows up to 8 instructions per thread per cycle, code 1 allows 4, code 2 allows 2 and code 3 allows 1. Instructions beyond the cap are not issued, and the slots they would have used stay open for higher-numbered threads.
- R7: A ready count above 8 is treated as 8. A ready count of 0 requests nothing.
- R8: Class code 3 is reserved. An instruction with that code never issues and stops its thread as in R5.
- R9: In paired mode, integer slot k accepts only threads 2k and 2k+1. Floating-point and load/store slots stay open to every thread.
- R10: In single-thread mode, only the thread named by the rotating pointer may issue. The pointer advances by one, wrapping from 7 to 0, on every edge at which the sampled single-thread flag is set.
- R11: An unused slot shows owner 0. The per-thread counts add up to the number of valid slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cnt_i | input | 32 | Ready count per thread, 4 bits each, thread t at bits [4t+3:4t] |
| req_cls_i | input | 128 | Class tag per instruction, 2 bits each, instruction i of thread t at bits [2(8t+i)+1:2(8t+i)] |
| cap_mode_i | input | 2 | Per-thread issue cap code (R6) |
| lim_mode_i | input | 1 | Paired integer mode enable |
| fg_mode_i | input | 1 | Single-thread rotating mode enable |
| slot_vld_o | output | 8 | Slot granted this cycle, one bit per slot |
| slot_thr_o | output | 24 | Owning thread per slot, 3 bits each, slot s at bits [3s+2:3s] |
| thr_cnt_o | output | 32 | Issued count per thread, 4 bits each |

## Verification
The sweeps target the stop-at-first-miss rule. A design that skipped an instruction it could not place and went on to later ones would show counts and slot owners that are too high. Counts of 9 and above and the reserved class code are mixed into the stimulus. A design that did not clamp the count, or that treated code 3 as a real class, would grant too many slots or grant slots of the wrong type. Paired mode is stressed with both threads of a pair asking for the same integer slot. A wrong pair decode would hand the slot to the wrong thread or to no thread at all. In single-thread mode the expected owner follows the pointer across runs that switch the mode on and off, so a pointer that advanced at the wrong edges would grant the wrong thread.

// File: rtl/smt_alloc_pkg.sv
package smt_alloc_pkg;

  typedef enum logic [1:0] {
    UCLS_INT = 2'd0,
    UCLS_FP  = 2'd1,
    UCLS_LS  = 2'd2,
    UCLS_RSV = 2'd3
  } ucls_e;

  // Translate the cap code into an instruction limit, bounded by the width.
  function automatic int cap_limit(input logic [1:0] code, input int maxw);
    int c;
    case (code)
      2'd0:    c = maxw;
      2'd1:    c = 4;
      2'd2:    c = 2;
      default: c = 1;
    endcase
    if (c > maxw) c = maxw;
    return c;
  endfunction

endpackage

// File: rtl/alloc_req_stage.sv
module alloc_req_stage #(
  parameter int NTHR   = 8,
  parameter int MAXREQ = 8,
  parameter int CW     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NTHR*CW-1:0]       cnt_i,
  input  logic [NTHR*MAXREQ*2-1:0] cls_i,
  input  logic [1:0]               cap_i,
  input  logic                     lim_i,
  input  logic                     fg_i,
  output logic [NTHR*CW-1:0]       cnt_q,
  output logic [NTHR*MAXREQ*2-1:0] cls_q,
  output logic [1:0]               cap_q,
  output logic                     lim_q,
  output logic                     fg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cls_q <= '0;
      cap_q <= '0;
      lim_q <= 1'b0;
      fg_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_i;
      cls_q <= cls_i;
      cap_q <= cap_i;
      lim_q <= lim_i;
      fg_q  <= fg_i;
    end
  end

endmodule

// File: rtl/alloc_rr_pointer.sv
module alloc_rr_pointer #(
  parameter int NTHR = 8,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  output logic [TW-1:0] ptr_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_o <= '0;
    end else if (adv_i) begin
      if (int'(ptr_o) == NTHR - 1) ptr_o <= '0;
      else                         ptr_o <= ptr_o + 1'b1;
    end
  end

endmodule

// File: rtl/alloc_core.sv
module alloc_core
  import smt_alloc_pkg::*;
#(
  parameter int NTHR   = 8,
  parameter int NINT   = 4,
  parameter int NFP    = 2,
  parameter int NLS    = 2,
  localparam int NSLOT  = NINT + NFP + NLS,
  localparam int MAXREQ = NSLOT,
  localparam int TW     = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CW     = $clog2(MAXREQ + 1)
) (
  input  logic [NTHR*CW-1:0]       cnt_i,
  input  logic [NTHR*MAXREQ*2-1:0] cls_i,
  input  logic [1:0]               cap_i,
  input  logic                     lim_i,
  input  logic                     fg_i,
  input  logic [TW-1:0]            ptr_i,
  output logic [NSLOT-1:0]         vld_o,
  output logic [NSLOT*TW-1:0]      thr_o,
  output logic [NTHR*CW-1:0]       cnt_o
);

  // Class served by slot s: integer slots first, then FP, then load/store.
  function automatic logic [1:0] slot_class(input int s);
    if (s < NINT)            return UCLS_INT;
    else if (s < NINT + NFP) return UCLS_FP;
    else                     return UCLS_LS;
  endfunction

  function automatic logic slot_ok(input int s, input int t,
                                   input logic [1:0] c, input logic lim);
    logic ok;
    ok = (c != UCLS_RSV) && (c == slot_class(s));
    if (lim && (s < NINT) && ((t / 2) != s)) ok = 1'b0;
    return ok;
  endfunction

  logic [NSLOT-1:0] busy;
  int               capv;
  int               want;
  int               got;
  logic             halt;
  logic             hit;
  logic [1:0]       cur_cls;

  always_comb begin
    busy    = '0;
    vld_o   = '0;
    thr_o   = '0;
    cnt_o   = '0;
    want    = 0;
    got     = 0;
    halt    = 1'b0;
    hit     = 1'b0;
    cur_cls = '0;
    capv    = cap_limit(cap_i, MAXREQ);
    for (int t = 0; t < NTHR; t++) begin
      want = int'(cnt_i[t*CW +: CW]);
      if (want > MAXREQ) want = MAXREQ;
      if (want > capv)   want = capv;
      if (fg_i && (t != int'(ptr_i))) want = 0;
      got  = 0;
      halt = 1'b0;
      for (int i = 0; i < MAXREQ; i++) begin
        if (!halt && (i < want)) begin
          cur_cls = cls_i[(t*MAXREQ + i)*2 +: 2];
          hit     = 1'b0;
          for (int s = 0; s < NSLOT; s++) begin
            if (!hit && !busy[s] && slot_ok(s, t, cur_cls, lim_i)) begin
              busy[s]           = 1'b1;
              vld_o[s]          = 1'b1;
              thr_o[s*TW +: TW] = TW'(t);
              hit               = 1'b1;
            end
          end
          if (hit) got = got + 1;
          else     halt = 1'b1;
        end
      end
      cnt_o[t*CW +: CW] = CW'(got);
    end
  end

endmodule

// File: rtl/alloc_grant_reg.sv
module alloc_grant_reg #(
  parameter int NSLOT = 8,
  parameter int NTHR  = 8,
  parameter int TW    = 3,
  parameter int CW    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSLOT-1:0]    vld_d,
  input  logic [NSLOT*TW-1:0] thr_d,
  input  logic [NTHR*CW-1:0]  cnt_d,
  output logic [NSLOT-1:0]    vld_q,
  output logic [NSLOT*TW-1:0] thr_q,
  output logic [NTHR*CW-1:0]  cnt_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      thr_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_d;
      thr_q <= thr_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/smt_issue_alloc.sv
module smt_issue_alloc
  import smt_alloc_pkg::*;
#(
  parameter int NTHR = 8,
  parameter int NINT = 4,
  parameter int NFP  = 2,
  parameter int NLS  = 2,
  localparam int NSLOT  = NINT + NFP + NLS,
  localparam int MAXREQ = NSLOT,
  localparam int TW     = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CW     = $clog2(MAXREQ + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NTHR*CW-1:0]       req_cnt_i,
  input  logic [NTHR*MAXREQ*2-1:0] req_cls_i,
  input  logic [1:0]               cap_mode_i,
  input  logic                     lim_mode_i,
  input  logic                     fg_mode_i,
  output logic [NSLOT-1:0]         slot_vld_o,
  output logic [NSLOT*TW-1:0]      slot_thr_o,
  output logic [NTHR*CW-1:0]       thr_cnt_o
);

  logic [NTHR*CW-1:0]       cnt_q;
  logic [NTHR*MAXREQ*2-1:0] cls_q;
  logic [1:0]               cap_q;
  logic                     lim_q;
  logic                     fg_q;
  logic [TW-1:0]            ptr;
  logic [NSLOT-1:0]         vld_d;
  logic [NSLOT*TW-1:0]      thr_d;
  logic [NTHR*CW-1:0]       cnt_d;

  alloc_req_stage #(.NTHR(NTHR), .MAXREQ(MAXREQ), .CW(CW)) u_req (
    .clk(clk), .rst(rst),
    .cnt_i(req_cnt_i), .cls_i(req_cls_i), .cap_i(cap_mode_i),
    .lim_i(lim_mode_i), .fg_i(fg_mode_i),
    .cnt_q(cnt_q), .cls_q(cls_q), .cap_q(cap_q), .lim_q(lim_q), .fg_q(fg_q)
  );

  alloc_rr_pointer #(.NTHR(NTHR)) u_ptr (
    .clk(clk), .rst(rst), .adv_i(fg_q), .ptr_o(ptr)
  );

  alloc_core #(.NTHR(NTHR), .NINT(NINT), .NFP(NFP), .NLS(NLS)) u_core (
    .cnt_i(cnt_q), .cls_i(cls_q), .cap_i(cap_q), .lim_i(lim_q),
    .fg_i(fg_q), .ptr_i(ptr),
    .vld_o(vld_d), .thr_o(thr_d), .cnt_o(cnt_d)
  );

  alloc_grant_reg #(.NSLOT(NSLOT), .NTHR(NTHR), .TW(TW), .CW(CW)) u_gnt (
    .clk(clk), .rst(rst),
    .vld_d(vld_d), .thr_d(thr_d), .cnt_d(cnt_d),
    .vld_q(slot_vld_o), .thr_q(slot_thr_o), .cnt_q(thr_cnt_o)
  );

  // Checks on the registered grants against the sampled controls.
  int              cap_now;
  int              tally;
  logic [NTHR-1:0] nz;

  assign cap_now = cap_limit(cap_q, MAXREQ);

  always_comb begin
    tally = 0;
    for (int t = 0; t < NTHR; t++) begin
      tally = tally + int'(thr_cnt_o[t*CW +: CW]);
      nz[t] = |thr_cnt_o[t*CW +: CW];
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (slot_vld_o == '0 && thr_cnt_o == '0 && slot_thr_o == '0));

  p_tally_r11: assert property (@(posedge clk) disable iff (rst)
    tally == $countones(slot_vld_o));

  p_single_thread_r10: assert property (@(posedge clk) disable iff (rst)
    $past(fg_q) |-> $onehot0(nz));

  generate
    for (genvar t = 0; t < NTHR; t++) begin : g_thr_chk
      p_cap_bound_r6: assert property (@(posedge clk) disable iff (rst)
        int'(thr_cnt_o[t*CW +: CW]) <= $past(cap_now));
    end
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot_chk
      p_idle_owner_r11: assert property (@(posedge clk) disable iff (rst)
        !slot_vld_o[s] |-> (slot_thr_o[s*TW +: TW] == '0));
    end
    for (genvar k = 0; k < NINT; k++) begin : g_pair_chk
      p_pair_bind_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(lim_q) && slot_vld_o[k]) |-> (int'(slot_thr_o[k*TW +: TW]) / 2 == k));
    end
  endgenerate

endmodule

// File: tb/sim_smt_issue_alloc.sv
module sim_smt_issue_alloc;

  localparam int NTHR = 8, NINT = 4, NFP = 2, NLS = 2;
  localparam int NSLOT = 8, MAXREQ = 8, TW = 3, CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NTHR*CW-1:0]       req_cnt = '0;
  logic [NTHR*MAXREQ*2-1:0] req_cls = '0;
  logic [1:0]               cap_mode = '0;
  logic                     lim_mode = 1'b0;
  logic                     fg_mode = 1'b0;
  logic [NSLOT-1:0]         slot_vld;
  logic [NSLOT*TW-1:0]      slot_thr;
  logic [NTHR*CW-1:0]       thr_cnt;

  smt_issue_alloc u0 (
    .clk(clk), .rst(rst), .req_cnt_i(req_cnt), .req_cls_i(req_cls),
    .cap_mode_i(cap_mode), .lim_mode_i(lim_mode), .fg_mode_i(fg_mode),
    .slot_vld_o(slot_vld), .slot_thr_o(slot_thr), .thr_cnt_o(thr_cnt)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  int a_cnt[NTHR];
  int a_cls[NTHR][MAXREQ];
  int e_vld[NSLOT], e_thr[NSLOT], e_cnt[NTHR];
  int ptr_m = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_req();
    for (int t = 0; t < NTHR; t++) begin
      a_cnt[t] = 0;
      for (int i = 0; i < MAXREQ; i++) a_cls[t][i] = 0;
    end
  endtask

  task automatic drive();
    for (int t = 0; t < NTHR; t++) begin
      req_cnt[t*CW +: CW] = CW'(a_cnt[t]);
      for (int i = 0; i < MAXREQ; i++) req_cls[(t*MAXREQ+i)*2 +: 2] = 2'(a_cls[t][i]);
    end
  endtask

  // Reference: per-class occupancy counters, pair flags for paired mode.
  task automatic model();
    int capv, nint, nfp, nls, lim, sl;
    bit pair_used[NINT];
    case (cap_mode)
      2'd0: capv = 8;
      2'd1: capv = 4;
      2'd2: capv = 2;
      default: capv = 1;
    endcase
    nint = 0; nfp = 0; nls = 0;
    for (int k = 0; k < NINT; k++) pair_used[k] = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin e_vld[s] = 0; e_thr[s] = 0; end
    for (int t = 0; t < NTHR; t++) begin
      e_cnt[t] = 0;
      if (fg_mode && t != ptr_m) continue;
      lim = (a_cnt[t] > 8) ? 8 : a_cnt[t];
      if (lim > capv) lim = capv;
      for (int i = 0; i < lim; i++) begin
        sl = -1;
        case (a_cls[t][i])
          0: if (lim_mode) begin
               if (!pair_used[t/2]) begin sl = t/2; pair_used[t/2] = 1'b1; end
             end else if (nint < NINT) begin sl = nint; nint++; end
          1: if (nfp < NFP) begin sl = NINT + nfp; nfp++; end
          2: if (nls < NLS) begin sl = NINT + NFP + nls; nls++; end
          default: sl = -1;
        endcase
        if (sl < 0) break;
        e_vld[sl] = 1; e_thr[sl] = t; e_cnt[t]++;
      end
    end
  endtask

  task automatic run_vec(input string tag);
    drive();
    model();
    @(posedge clk); @(posedge clk); @(negedge clk);
    for (int s = 0; s < NSLOT; s++) begin
      check(int'(slot_vld[s]) == e_vld[s], tag, $sformatf("slot %0d valid", s),
            int'(slot_vld[s]), e_vld[s]);
      check(int'(slot_thr[s*TW +: TW]) == e_thr[s], tag, $sformatf("slot %0d owner", s),
            int'(slot_thr[s*TW +: TW]), e_thr[s]);
    end
    for (int t = 0; t < NTHR; t++)
      check(int'(thr_cnt[t*CW +: CW]) == e_cnt[t], tag, $sformatf("thread %0d count", t),
            int'(thr_cnt[t*CW +: CW]), e_cnt[t]);
    if (fg_mode) ptr_m = (ptr_m + 2) % NTHR;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    clear_req();
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared by reset
    check(slot_vld == '0, "R1", "valid after reset", int'(slot_vld), 0);
    check(thr_cnt == '0, "R1", "counts after reset", int'(thr_cnt), 0);

    // R2: two-edge latency
    a_cnt[0] = 1; drive();
    @(posedge clk); @(negedge clk);
    check(slot_vld == '0, "R2", "valid after one edge", int'(slot_vld), 0);
    @(posedge clk); @(negedge clk);
    check(slot_vld == 8'h01, "R2", "valid after two edges", int'(slot_vld), 1);

    // R7: count 12 clamps to 8 across all classes
    clear_req(); a_cnt[0] = 12;
    for (int i = 0; i < 8; i++) a_cls[0][i] = (i < 4) ? 0 : (i < 6) ? 1 : 2;
    run_vec("R7");
    check(int'(thr_cnt[3:0]) == 8, "R7", "clamped count", int'(thr_cnt[3:0]), 8);

    // R8: reserved code stops thread 0 after one issue; thread 1 fills next ints
    clear_req(); a_cnt[0] = 5; a_cls[0][1] = 3; a_cnt[1] = 2;
    run_vec("R8");
    check(int'(thr_cnt[3:0]) == 1, "R8", "reserved stops thread", int'(thr_cnt[3:0]), 1);

    // R5: in-order stop; int after three FP is not issued, thread 1 gets slot 0
    clear_req(); a_cnt[0] = 4;
    a_cls[0][0] = 1; a_cls[0][1] = 1; a_cls[0][2] = 1; a_cls[0][3] = 0;
    a_cnt[1] = 1;
    run_vec("R5");
    check(int'(slot_thr[2:0]) == 1, "R5", "slot 0 owner", int'(slot_thr[2:0]), 1);

    // R9: paired mode, every thread asks one integer slot
    clear_req(); lim_mode = 1'b1;
    for (int t = 0; t < NTHR; t++) a_cnt[t] = 1;
    run_vec("R9");
    check(int'(thr_cnt[7:4]) == 0, "R9", "thread 1 loses its pair", int'(thr_cnt[7:4]), 0);
    lim_mode = 1'b0;

    // R6: each cap code, thread 0 asks 8 mixed, thread 7 takes leftovers
    for (int c = 0; c < 4; c++) begin
      clear_req(); cap_mode = 2'(c); a_cnt[0] = 8; a_cnt[7] = 8;
      for (int i = 0; i < 8; i++) begin a_cls[0][i] = 0; a_cls[7][i] = 0; end
      run_vec("R6 R3");
    end
    cap_mode = 2'd0;

    // R10: single-thread rotation, all threads ready
    fg_mode = 1'b1;
    for (int n = 0; n < 6; n++) begin
      clear_req();
      for (int t = 0; t < NTHR; t++) a_cnt[t] = 2;
      run_vec("R10");
    end
    fg_mode = 1'b0;

    // Sweep: R3 R4 R5 R6 R7 R8 R9 R10 R11 over every mode combination
    for (int cm = 0; cm < 4; cm++)
      for (int lm = 0; lm < 2; lm++)
        for (int fm = 0; fm < 2; fm++)
          for (int v = 0; v < 60; v++) begin
            cap_mode = 2'(cm); lim_mode = lm[0]; fg_mode = fm[0];
            for (int t = 0; t < NTHR; t++) begin
              a_cnt[t] = $urandom_range(0, 10) % 10;
              for (int i = 0; i < MAXREQ; i++) begin
                r = $urandom_range(0, 15);
                a_cls[t][i] = (r == 15) ? 3 : (r % 3);
              end
            end
            run_vec("R3 R4 R5 R11 sweep");
          end

    // R1: reset in the middle of traffic
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(slot_vld == '0, "R1", "valid after late reset", int'(slot_vld), 0);
    check(slot_thr == '0, "R1", "owners after late reset", int'(slot_thr), 0);
    check(thr_cnt == '0, "R1", "counts after late reset", int'(thr_cnt), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule